// File: doc/BRIEF.md
# Direct-Store Segment Access Checker

This block decides the outcome of a memory access that falls in a segment marked for direct-store handling. It receives the 32-bit segment descriptor, the effective address, the access kind (load, store or instruction fetch), the access class and the privilege state. It answers with either a grant, carrying a real address and a permission set, or a fault, carrying a fault type, a status word and the captured address. An input encoding outside the defined set raises an error flag instead.

One descriptor pattern, a bus-unit ID field equal to a reserved value, forwards the access straight to memory with full rights. Every other access is sorted by class: integer accesses are checked against a protection key, cache-management accesses complete as no-ops, and the remaining classes each produce their own fault with a distinct status word. The answer is registered and appears exactly one clock after the request.

Top module: `dstore_seg_check`

## Requirements
- R1: The response appears one clock after the request: `rsp_valid` is high in the cycle after `req_valid` was high. In any cycle after a cycle with no request, and while in reset, all outputs are zero.
- R2: When descriptor bits 28..20 equal 0x07F, the access is granted with permission 3'b111 (bit 2 read, bit 1 write, bit 0 execute) and real address {descriptor bits 3..0, address bits 27..0}, whatever the class, kind and key.
- R3: Otherwise an instruction fetch (kind 2) faults with fault type 1 (instruction), status 0x10000000 and captured address 0, whatever the class.
- R4: A floating-point class access (class 1) faults with fault type 3 (alignment), status 0 and captured address equal to the effective address.
- R5: A reservation class access (class 2) faults with fault type 2 (data), status 0x06000000 for a store and 0x04000000 for a load, and captures the address.
- R6: A cache-management class access (class 3) is granted as a no-op with real address equal to the effective address and permission 3'b110.
- R7: An external-control class access (class 4) faults with fault type 2, status 0x06100000 for a store and 0x04100000 for a load, and captures the address.
- R8: The protection key is descriptor bit 29 when `user_mode` is high and descriptor bit 30 otherwise.
- R9: An integer class access (class 0) is granted with real address equal to the effective address and permission 3'b110, except a load (kind 0) with key 1 or a store (kind 1) with key 0, which fault with fault type 2, status 0x08000000 (load) or 0x0A000000 (store), and capture the address.
- R10: Kind 3 always raises `rsp_error`; a class value above 4 raises `rsp_error` when neither R2 nor R3 applies. With an error, grant, fault and every data output are zero.
- R11: In every valid response exactly one of `rsp_grant`, `rsp_fault` and `rsp_error` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| seg_desc | input | 32 | Segment descriptor of the access |
| eff_addr | input | 32 | Effective address |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 illegal |
| acc_class | input | 3 | 0 integer, 1 floating-point, 2 reservation, 3 cache-management, 4 external-control |
| user_mode | input | 1 | High for user privilege |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access granted |
| rsp_fault | output | 1 | Access faulted |
| rsp_error | output | 1 | Illegal input encoding |
| real_addr | output | 32 | Real address of a grant |
| perm | output | 3 | Read, write, execute of a grant |
| fault_type | output | 2 | 0 none, 1 instruction, 2 data, 3 alignment |
| fault_status | output | 32 | Status word of a fault |
| fault_addr | output | 32 | Captured address of a fault |

## Verification
Directed requests walk every class with load and store under both privilege states and both key bit values, so a swapped key source or swapped load/store status shows as a wrong grant or status. Bypass-ID descriptors are combined with fetches, illegal classes and faulting integer keys to show the bypass wins over all of them, and near-miss IDs show it is not taken by accident. Fetches with each class, and illegal kinds and classes, separate the order of the checks, while idle gaps between back-to-back requests show the one-cycle latency and the cleared idle outputs. A long random run then compares every response against the bench model.

// File: rtl/dstore_seg_check.sv
module dstore_seg_check #(
  parameter logic [8:0] BYPASS_ID = 9'h07F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] seg_desc,
  input  logic [31:0] eff_addr,
  input  logic [1:0]  acc_kind,
  input  logic [2:0]  acc_class,
  input  logic        user_mode,
  output logic        rsp_valid,
  output logic        rsp_grant,
  output logic        rsp_fault,
  output logic        rsp_error,
  output logic [31:0] real_addr,
  output logic [2:0]  perm,
  output logic [1:0]  fault_type,
  output logic [31:0] fault_status,
  output logic [31:0] fault_addr
);
  localparam logic [1:0] K_LOAD = 2'd0, K_STORE = 2'd1, K_FETCH = 2'd2;
  localparam logic [2:0] C_INT = 3'd0, C_FP = 3'd1, C_RES = 3'd2, C_CACHE = 3'd3, C_EXT = 3'd4;
  localparam logic [1:0] FT_INSTR = 2'd1, FT_DATA = 2'd2, FT_ALIGN = 2'd3;

  wire key      = user_mode ? seg_desc[29] : seg_desc[30];
  wire is_store = (acc_kind == K_STORE);
  wire bypass   = (seg_desc[28:20] == BYPASS_ID);

  logic        n_grant, n_fault, n_err;
  logic [2:0]  n_perm;
  logic [1:0]  n_ft;
  logic [31:0] n_st, n_fa, n_ra;

  always_comb begin
    n_grant = 1'b0; n_fault = 1'b0; n_err = 1'b0;
    n_perm = 3'b000; n_ft = 2'd0; n_st = 32'h0; n_fa = 32'h0; n_ra = 32'h0;
    if (!req_valid) begin
    end else if (acc_kind == 2'd3) begin
      n_err = 1'b1;
    end else if (bypass) begin
      n_grant = 1'b1; n_perm = 3'b111;
      n_ra = {seg_desc[3:0], eff_addr[27:0]};
    end else if (acc_kind == K_FETCH) begin
      n_fault = 1'b1; n_ft = FT_INSTR; n_st = 32'h1000_0000;
    end else begin
      case (acc_class)
        C_INT: begin
          if ((acc_kind == K_LOAD && key) || (is_store && !key)) begin
            n_fault = 1'b1; n_ft = FT_DATA; n_fa = eff_addr;
            n_st = is_store ? 32'h0A00_0000 : 32'h0800_0000;
          end else begin
            n_grant = 1'b1; n_perm = 3'b110; n_ra = eff_addr;
          end
        end
        C_FP: begin
          n_fault = 1'b1; n_ft = FT_ALIGN; n_fa = eff_addr;
        end
        C_RES: begin
          n_fault = 1'b1; n_ft = FT_DATA; n_fa = eff_addr;
          n_st = is_store ? 32'h0600_0000 : 32'h0400_0000;
        end
        C_CACHE: begin
          n_grant = 1'b1; n_perm = 3'b110; n_ra = eff_addr;
        end
        C_EXT: begin
          n_fault = 1'b1; n_ft = FT_DATA; n_fa = eff_addr;
          n_st = is_store ? 32'h0610_0000 : 32'h0410_0000;
        end
        default: n_err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_grant <= 1'b0; rsp_fault <= 1'b0; rsp_error <= 1'b0;
      real_addr <= 32'h0; perm <= 3'b000; fault_type <= 2'd0;
      fault_status <= 32'h0; fault_addr <= 32'h0;
    end else begin
      rsp_valid <= req_valid; rsp_grant <= n_grant; rsp_fault <= n_fault; rsp_error <= n_err;
      real_addr <= n_ra; perm <= n_perm; fault_type <= n_ft;
      fault_status <= n_st; fault_addr <= n_fa;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_grant && !rsp_fault && !rsp_error && real_addr == 32'h0);
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_kind != 2'd3 && seg_desc[28:20] == BYPASS_ID |=>
      rsp_grant && perm == 3'b111 && real_addr[27:0] == $past(eff_addr[27:0])
      && real_addr[31:28] == $past(seg_desc[3:0]));
  p_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_kind == K_FETCH && seg_desc[28:20] != BYPASS_ID |=>
      rsp_fault && fault_type == FT_INSTR && fault_status == 32'h1000_0000);
  p_cache_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_class == C_CACHE && !acc_kind[1] && seg_desc[28:20] != BYPASS_ID |=>
      rsp_grant && real_addr == $past(eff_addr));
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_grant, rsp_fault, rsp_error}));
  p_error_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> perm == 3'b000 && fault_status == 32'h0 && fault_addr == 32'h0);
endmodule

// File: tb/tb_dstore_seg_check.sv
module tb_dstore_seg_check;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, user_mode;
  logic [31:0] seg_desc, eff_addr;
  logic [1:0] acc_kind;
  logic [2:0] acc_class;
  logic rsp_valid, rsp_grant, rsp_fault, rsp_error;
  logic [31:0] real_addr, fault_status, fault_addr;
  logic [2:0] perm;
  logic [1:0] fault_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [104:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dstore_seg_check dut (.*);

  function automatic logic [104:0] model(input logic v, input logic [31:0] sd, input logic [31:0] ea,
                                          input logic [1:0] k, input logic [2:0] c, input logic u);
    logic g, f, e; logic [2:0] p; logic [1:0] t; logic [31:0] s, fa, ra; logic kb;
    g = 0; f = 0; e = 0; p = 0; t = 0; s = 0; fa = 0; ra = 0;
    kb = u ? sd[29] : sd[30];
    if (v) begin
      if (k == 3) e = 1;
      else if (sd[28:20] == 9'h07F) begin g = 1; p = 3'b111; ra = {sd[3:0], ea[27:0]}; end
      else if (k == 2) begin f = 1; t = 1; s = 32'h1000_0000; end
      else if (c == 0) begin
        if (k == 0 && kb == 1) begin f = 1; t = 2; s = 32'h0800_0000; fa = ea; end
        else if (k == 1 && kb == 0) begin f = 1; t = 2; s = 32'h0A00_0000; fa = ea; end
        else begin g = 1; p = 3'b110; ra = ea; end
      end
      else if (c == 1) begin f = 1; t = 3; fa = ea; end
      else if (c == 2) begin f = 1; t = 2; fa = ea; s = (k == 1) ? 32'h0600_0000 : 32'h0400_0000; end
      else if (c == 3) begin g = 1; p = 3'b110; ra = ea; end
      else if (c == 4) begin f = 1; t = 2; fa = ea; s = (k == 1) ? 32'h0610_0000 : 32'h0410_0000; end
      else e = 1;
    end
    return {v, g, f, e, p, t, s, fa, ra};
  endfunction

  function automatic logic [104:0] actual();
    return {rsp_valid, rsp_grant, rsp_fault, rsp_error, perm, fault_type, fault_status, fault_addr, real_addr};
  endfunction

  task automatic compare(input logic [104:0] exp, input string tag);
    checks++;
    if (actual() !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] sd, input logic [31:0] ea,
                      input logic [1:0] k, input logic [2:0] c, input logic u, input string tag);
    @(negedge clk);
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    req_valid = v; seg_desc = sd; eff_addr = ea; acc_kind = k; acc_class = c; user_mode = u;
    exp_q.push_back(model(v, sd, ea, k, c, u));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 32'h0, 2'd0, 3'd0, 1'b0, tag);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; seg_desc = 0; eff_addr = 0; acc_kind = 0; acc_class = 0; user_mode = 0;
    repeat (3) @(negedge clk);
    compare('0, "R1 reset");
    rst_n = 1'b1;
    idle("R1");
    // R2 bypass beats fetch, illegal class and faulting key
    step(1, 32'h87F0_000A, 32'hF123_4567, 2'd0, 3'd0, 1'b0, "R2");
    step(1, 32'h07F0_0003, 32'h1234_5678, 2'd2, 3'd7, 1'b1, "R2");
    step(1, 32'h47F0_000F, 32'hFFFF_FFFF, 2'd0, 3'd0, 1'b0, "R2");
    step(1, 32'h07E0_0005, 32'h0000_1000, 2'd1, 3'd3, 1'b0, "R2 near miss");
    step(1, 32'h0FF0_0005, 32'h0000_2000, 2'd0, 3'd3, 1'b0, "R2 near miss");
    idle("R1");
    // R3 fetch with every class
    for (int c = 0; c < 8; c++) step(1, 32'h8000_0000, 32'hABCD_0000 + c, 2'd2, 3'(c), 1'b0, "R3");
    // R4 floating point
    step(1, 32'h8000_0000, 32'h0000_0044, 2'd0, 3'd1, 1'b0, "R4");
    step(1, 32'hE000_0000, 32'h0000_0048, 2'd1, 3'd1, 1'b1, "R4");
    // R5 reservation
    step(1, 32'h8000_0000, 32'h1111_0000, 2'd0, 3'd2, 1'b0, "R5");
    step(1, 32'h8000_0000, 32'h2222_0000, 2'd1, 3'd2, 1'b0, "R5");
    // R6 cache management
    step(1, 32'hC000_0000, 32'h3333_4444, 2'd0, 3'd3, 1'b0, "R6");
    step(1, 32'h8000_0000, 32'h5555_6666, 2'd1, 3'd3, 1'b1, "R6");
    // R7 external control
    step(1, 32'h8000_0000, 32'h7777_0000, 2'd0, 3'd4, 1'b0, "R7");
    step(1, 32'h8000_0000, 32'h8888_0000, 2'd1, 3'd4, 1'b1, "R7");
    idle("R1");
    // R8 and R9: all combinations of privilege, both key bits and kind
    for (int m = 0; m < 16; m++)
      step(1, {1'b1, m[1], m[0], 29'h0}, 32'h0BAD_0000 + m, {1'b0, m[3]}, 3'd0, m[2], (m[2] ? "R8 user R9" : "R8 super R9"));
    // R10 illegal encodings
    step(1, 32'h8000_0000, 32'h0000_0100, 2'd3, 3'd0, 1'b0, "R10");
    step(1, 32'h8000_0000, 32'h0000_0104, 2'd0, 3'd5, 1'b0, "R10");
    step(1, 32'h8000_0000, 32'h0000_0108, 2'd1, 3'd7, 1'b1, "R10");
    idle("R1");
    idle("R1");
    // R11 random mixture
    for (int i = 0; i < 400; i++) begin
      logic [31:0] sd;
      sd = $urandom;
      if (i % 5 == 0) sd[28:20] = 9'h07F;
      step(1'($urandom_range(0, 3) != 0), sd, $urandom, 2'($urandom), 3'($urandom), 1'($urandom), "R11 random");
    end
    idle("R1");
    idle("R1");
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule